// File: doc/BRIEF.md
# Programmable Parallel Port Interface

A bus-attached parallel I/O controller. It has three 8-bit ports, A, B and C, which form two control groups. The first group holds Port A and the high nibble of Port C. The second group holds Port B and the low nibble of Port C. A processor programs the block through a small register window. It selects one of four locations with a 2-bit address and moves data over separate input and output data buses, so the block has no tri-state nets. Each port has its own input vector and its own output vector.

Every processor-side signal and every port input passes through a chain of synchronizer flops before the logic uses it. An access takes effect once, on the synchronized rising edge of its strobe while chip select is high. Writing the control location does one of two things, chosen by bit 7. With bit 7 high, it sets the direction of each port and nibble and clears every output register. With bit 7 low, it sets or clears one bit of Port C. All ports behave as plain latched inputs or outputs. Group modes other than basic are stored in the control word, but they act like basic mode.

Top module: `ppi_core`

## Requirements
- R1: Reset (active low, synchronous) clears the three output registers and `dout`. The control register resets to all ports input, so it reads back as 0x9B.
- R2: The address selects the location: 0 is Port A, 1 is Port B, 2 is Port C and 3 is the control register.
- R3: A control write with bit 7 high stores bits 6:0. Readback returns those bits with bit 7 forced to 1. The bit fields are: 6:5 first-group mode, 4 Port A direction, 3 Port C high-nibble direction, 2 second-group mode, 1 Port B direction, 0 Port C low-nibble direction. A direction bit of 1 means input. Every mode value behaves as basic I/O.
- R4: A control write with bit 7 high clears all three output registers to zero.
- R5: A control write with bit 7 low writes data bit 0 into the Port C output bit indexed by data bits 3:1. The other Port C bits and the control register stay unchanged.
- R6: A write to address 0, 1 or 2 loads that port's output register whatever its direction. Each output vector always shows its output register.
- R7: Reading a port set as output returns its output register. Reading Port B set as input returns its synchronized input. Reading Port A set as input returns a capture register that samples the synchronized input every clock.
- R8: A Port C read returns each nibble from the input or the output register, chosen by that nibble's own direction bit.
- R9: An access happens once per rising strobe edge while chip select is high. A held strobe does not repeat the access, and a strobe with chip select low does nothing.
- R10: `dout` changes only on a detected read and holds the last read value in between.
- R11: With two synchronizer stages, if a write strobe rises before clock edge E0, the output register is unchanged after edge E1 and holds the new value after edge E2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| addr | input | 2 | Location select |
| din | input | 8 | Write data from the processor |
| dout | output | 8 | Read data to the processor, held between reads |
| pa_in | input | 8 | Port A input vector |
| pa_out | output | 8 | Port A output register |
| pb_in | input | 8 | Port B input vector |
| pb_out | output | 8 | Port B output register |
| pc_in | input | 8 | Port C input vector |
| pc_out | output | 8 | Port C output register |

## Verification
The bench holds a write strobe high and changes the data under it. A design that acts on the strobe level instead of its edge would load the second value. It issues a bit set/reset after a port write, and a design that decodes the command badly would change neighbouring Port C bits or corrupt the control readback. It splits the Port C nibbles so one is input and one is output, which catches a design that uses one direction bit for the whole port. It also counts the clock edges from a strobe to its output, to catch an extra or a missing pipeline stage. Last, it writes with chip select low, which a design that ignores the select would act on.

// File: rtl/ppi_pkg.sv
// Shared constants and types for the parallel port interface.
// Assumes an 8-bit processor bus and a 2-bit location select.
package ppi_pkg;
    localparam int DW = 8;
    localparam int AW = 2;

    typedef enum logic [AW-1:0] {
        SEL_A    = 2'd0,
        SEL_B    = 2'd1,
        SEL_C    = 2'd2,
        SEL_CTRL = 2'd3
    } sel_e;

    // control word bit positions
    localparam int CW_DEFINE  = 7;
    localparam int CW_A_DIR   = 4;
    localparam int CW_CHI_DIR = 3;
    localparam int CW_B_DIR   = 1;
    localparam int CW_CLO_DIR = 0;

    // reset control: all ports input, basic mode (reads back 0x9B)
    localparam logic [DW-2:0] CTRL_RESET = 7'h1B;
endpackage

// File: rtl/ppi_sync.sv
// Multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes STAGES >= 1. Each bit is synchronized on its own, with no
// coherence promised across bits that change in the same cycle.
module ppi_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // shift the vector one stage down the chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= '0;
                else if (s == 0) chain[s] <= d;
                else chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ppi_bus_front.sv
// Processor-side front end. It synchronizes chip select, the strobes,
// the address and the write data, and gives one-cycle read and write
// events on the rising edge of each synchronized strobe while the
// select is high. Assumes the address and data are steady while the
// strobe is asserted.
module ppi_bus_front #(
    parameter int DW     = 8,
    parameter int AW     = 2,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic          rd,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic          rd_evt,
    output logic          wr_evt,
    output logic [AW-1:0] addr_s,
    output logic [DW-1:0] din_s
);
    localparam int BW = 3 + AW + DW;

    logic [BW-1:0] bus_s;
    logic          cs_s, rd_s, wr_s;
    logic          rd_d, wr_d;

    ppi_sync #(.W(BW), .STAGES(STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs, rd, wr, addr, din}),
        .q     (bus_s)
    );

    assign {cs_s, rd_s, wr_s, addr_s, din_s} = bus_s;

    // remember the previous strobe levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_d <= 1'b0;
            wr_d <= 1'b0;
        end else begin
            rd_d <= rd_s;
            wr_d <= wr_s;
        end
    end

    assign rd_evt = cs_s & rd_s & ~rd_d;
    assign wr_evt = cs_s & wr_s & ~wr_d;

    // R9
    single_wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_evt |=> !wr_evt);
    // R9
    single_rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_evt |=> !rd_evt);
endmodule

// File: rtl/ppi_core.sv
// Top of the parallel port interface: three 8-bit ports in two groups,
// a readable control word, and single-bit set/reset on Port C.
// Assumes one clock and a synchronous active-low reset. All other inputs
// are asynchronous and are synchronized here. Modes other than basic
// are stored but act as basic I/O.
module ppi_core
    import ppi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic          rd,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    input  logic [DW-1:0] pa_in,
    output logic [DW-1:0] pa_out,
    input  logic [DW-1:0] pb_in,
    output logic [DW-1:0] pb_out,
    input  logic [DW-1:0] pc_in,
    output logic [DW-1:0] pc_out
);
    localparam int NIB = DW / 2;

    logic          rd_evt, wr_evt;
    logic [AW-1:0] addr_s;
    logic [DW-1:0] din_s;
    logic [DW-1:0] pa_s, pb_s, pc_s;
    logic [DW-2:0] ctrl_q;
    logic [DW-1:0] pa_q, pb_q, pc_q, pa_cap, dout_q;
    logic [DW-1:0] pc_rd, rd_mux;
    logic [1:0]    pc_dir;
    sel_e          sel;

    ppi_bus_front #(.DW(DW), .AW(AW), .STAGES(SYNC_STAGES)) u_front (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs     (cs),
        .rd     (rd),
        .wr     (wr),
        .addr   (addr),
        .din    (din),
        .rd_evt (rd_evt),
        .wr_evt (wr_evt),
        .addr_s (addr_s),
        .din_s  (din_s)
    );

    ppi_sync #(.W(3*DW), .STAGES(SYNC_STAGES)) u_port_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({pa_in, pb_in, pc_in}),
        .q     ({pa_s, pb_s, pc_s})
    );

    assign sel    = sel_e'(addr_s);
    assign pc_dir = {ctrl_q[CW_CHI_DIR], ctrl_q[CW_CLO_DIR]};

    // apply processor writes: port loads, mode definition, bit set/reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
            pa_q   <= '0;
            pb_q   <= '0;
            pc_q   <= '0;
        end else if (wr_evt) begin
            case (sel)
                SEL_A: pa_q <= din_s;
                SEL_B: pb_q <= din_s;
                SEL_C: pc_q <= din_s;
                default: begin
                    if (din_s[CW_DEFINE]) begin
                        ctrl_q <= din_s[DW-2:0];
                        pa_q   <= '0;
                        pb_q   <= '0;
                        pc_q   <= '0;
                    end else begin
                        pc_q[din_s[3:1]] <= din_s[0];
                    end
                end
            endcase
        end
    end

    // Port A input capture register, sampled every clock
    always_ff @(posedge clk) begin
        if (!rst_n) pa_cap <= '0;
        else        pa_cap <= pa_s;
    end

    genvar n;
    generate
        for (n = 0; n < 2; n++) begin : g_pc_nib
            assign pc_rd[n*NIB +: NIB] = pc_dir[n] ? pc_s[n*NIB +: NIB]
                                                   : pc_q[n*NIB +: NIB];
        end
    endgenerate

    // select the read data for the addressed location
    always_comb begin
        case (sel)
            SEL_A:   rd_mux = ctrl_q[CW_A_DIR] ? pa_cap : pa_q;
            SEL_B:   rd_mux = ctrl_q[CW_B_DIR] ? pb_s : pb_q;
            SEL_C:   rd_mux = pc_rd;
            default: rd_mux = {1'b1, ctrl_q};
        endcase
    end

    // hold the read data from one read until the next
    always_ff @(posedge clk) begin
        if (!rst_n)      dout_q <= '0;
        else if (rd_evt) dout_q <= rd_mux;
    end

    assign dout   = dout_q;
    assign pa_out = pa_q;
    assign pb_out = pb_q;
    assign pc_out = pc_q;

    // R3
    ctrl_readback_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_evt && sel == SEL_CTRL) |=> dout[DW-1]);
    // R4
    define_clears_ports_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_evt && sel == SEL_CTRL && din_s[CW_DEFINE]) |=>
        (pa_out == '0 && pb_out == '0 && pc_out == '0));
    // R5
    bsr_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_evt && sel == SEL_CTRL && !din_s[CW_DEFINE]) |=>
        ($countones(pc_out ^ $past(pc_out)) <= 1 && $stable(pa_out) && $stable(pb_out)));
    // R9
    no_write_outputs_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_evt |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out)));
    // R10
    dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_evt |=> $stable(dout));
endmodule

// File: tb/test_ppi_core.sv
// Directed bench for ppi_core. Inputs are driven at the falling edge and
// outputs are sampled away from the rising edge.
module test_ppi_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] dout, pa_out, pb_out, pc_out;
    logic [7:0] pa_in = '0, pb_in = '0, pc_in = '0;
    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    ppi_core i_ppi_core (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr),
        .addr(addr), .din(din), .dout(dout),
        .pa_in(pa_in), .pa_out(pa_out),
        .pb_in(pb_in), .pb_out(pb_out),
        .pc_in(pc_in), .pc_out(pc_out)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input logic sel = 1'b1);
        @(negedge clk);
        cs = sel; addr = a; din = d; wr = 1'b1;
        repeat (4) @(negedge clk);
        wr = 1'b0;
        repeat (3) @(negedge clk);
        cs = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d, input logic sel = 1'b1);
        @(negedge clk);
        cs = sel; addr = a; rd = 1'b1;
        repeat (4) @(negedge clk);
        rd = 1'b0;
        repeat (3) @(negedge clk);
        cs = 1'b0;
        d = dout;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 pa_out", pa_out, 8'h00);
        chk("R1 pb_out", pb_out, 8'h00);
        chk("R1 pc_out", pc_out, 8'h00);
        chk("R1 dout", dout, 8'h00);
        bus_read(2'd3, v);
        chk("R1 R2 control reset readback", v, 8'h9B);
    endtask

    task automatic t_outputs();
        logic [7:0] v;
        bus_write(2'd3, 8'h80);
        pa_in = 8'hAA; pb_in = 8'h11;
        bus_write(2'd0, 8'h55);
        bus_write(2'd1, 8'h66);
        bus_write(2'd2, 8'h77);
        chk("R6 pa_out", pa_out, 8'h55);
        chk("R6 pb_out", pb_out, 8'h66);
        chk("R6 pc_out", pc_out, 8'h77);
        bus_read(2'd0, v); chk("R7 R2 read A output", v, 8'h55);
        bus_read(2'd1, v); chk("R7 read B output", v, 8'h66);
        bus_read(2'd2, v); chk("R8 read C output", v, 8'h77);
    endtask

    task automatic t_modes();
        logic [7:0] v;
        bus_write(2'd3, 8'hE4);
        chk("R4 pa cleared", pa_out, 8'h00);
        chk("R4 pc cleared", pc_out, 8'h00);
        bus_read(2'd3, v); chk("R3 control readback", v, 8'hE4);
        bus_write(2'd0, 8'h3A);
        bus_read(2'd0, v); chk("R3 strobed mode acts as basic", v, 8'h3A);
        bus_write(2'd3, 8'h64);
        bus_read(2'd3, v); chk("R3 bit7 forced", v, 8'hE4);
    endtask

    task automatic t_inputs();
        logic [7:0] v;
        bus_write(2'd0, 8'h12);
        bus_write(2'd3, 8'h9B);
        chk("R4 pa cleared by define", pa_out, 8'h00);
        pa_in = 8'h3C; pb_in = 8'hC3; pc_in = 8'h5A;
        repeat (4) @(negedge clk);
        bus_read(2'd0, v); chk("R7 read A input", v, 8'h3C);
        bus_read(2'd1, v); chk("R7 read B input", v, 8'hC3);
        bus_read(2'd2, v); chk("R8 read C input", v, 8'h5A);
        bus_write(2'd1, 8'h99);
        chk("R6 write to input port loads register", pb_out, 8'h99);
    endtask

    task automatic t_nibbles();
        logic [7:0] v;
        bus_write(2'd3, 8'h88);
        bus_write(2'd2, 8'h7E);
        pc_in = 8'h5A;
        bus_read(2'd2, v); chk("R8 high in low out", v, 8'h5E);
        bus_write(2'd3, 8'h81);
        bus_write(2'd2, 8'h7E);
        bus_read(2'd2, v); chk("R8 high out low in", v, 8'h7A);
    endtask

    task automatic t_bsr();
        logic [7:0] v;
        bus_write(2'd3, 8'h80);
        bus_write(2'd0, 8'h44);
        bus_write(2'd3, 8'h0B);
        chk("R5 set bit5", pc_out, 8'h20);
        bus_write(2'd3, 8'h01);
        chk("R5 set bit0", pc_out, 8'h21);
        bus_write(2'd3, 8'h0F);
        chk("R5 set bit7", pc_out, 8'hA1);
        bus_write(2'd3, 8'h0A);
        chk("R5 clear bit5", pc_out, 8'h81);
        chk("R5 port A untouched", pa_out, 8'h44);
        bus_read(2'd3, v); chk("R5 control unchanged", v, 8'h80);
    endtask

    task automatic t_select_and_hold();
        logic [7:0] v;
        bus_write(2'd0, 8'hFF, 1'b0);
        chk("R9 cs low write ignored", pa_out, 8'h44);
        @(negedge clk);
        cs = 1'b1; addr = 2'd1; din = 8'h11; wr = 1'b1;
        repeat (4) @(negedge clk);
        din = 8'h22;
        repeat (4) @(negedge clk);
        wr = 1'b0;
        repeat (3) @(negedge clk);
        cs = 1'b0;
        chk("R9 held strobe acts once", pb_out, 8'h11);
        bus_read(2'd1, v); chk("R10 read B", v, 8'h11);
        bus_read(2'd0, v, 1'b0);
        chk("R10 dout held after cs-low read", v, 8'h11);
    endtask

    task automatic t_latency();
        bus_write(2'd3, 8'h80);
        @(negedge clk);
        cs = 1'b1; addr = 2'd1; din = 8'hA5; wr = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        chk("R11 unchanged after E1", pb_out, 8'h00);
        @(posedge clk); #1;
        chk("R11 updated after E2", pb_out, 8'hA5);
        @(negedge clk); wr = 1'b0;
        repeat (4) @(negedge clk);
        cs = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_outputs();
        t_modes();
        t_inputs();
        t_nibbles();
        t_bsr();
        t_select_and_hold();
        t_latency();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule